// File: doc/BRIEF.md
# Two-Profile Clock Output Divider Bank

The block drives eight clock outputs from six source clocks. Each source reaches it as a one-cycle strobe sampled by a single fast system clock, so the entire bank runs in one clock domain. Each output follows the strobes of its chosen source and divides them by an 8-bit ratio. The result is a registered, duty-controlled output level.

Two complete settings tables are kept in registers. Each table holds a source choice and a ratio for every output. A select input picks the live table, and a control bit gates that input. Table changes reach an output only at the end of its current period, so no output shows a short pulse. A source change first holds the output low for one full period of the old source.

A separate active-high device reset input holds every output low. It works in one of two programmable ways. In one, the tables return to their defaults. In the other, the tables are kept and every enabled output restarts in phase when the reset is released.

Top module: `clkout_div_bank`

## Requirements
- R1: With ratio N (2..255) on a source, an output repeats every N strobes of that source and stays high for the first floor(N/2) strobes of each period. Ratio 1 behaves as ratio 2. Ratio 0 holds the output low.
- R2: A source write that names a source index of 6 or above, or that would leave more than four distinct sources in that table, is not stored. `cfg_err` is high for exactly the one cycle after such a write and is low otherwise.
- R3: Table entries are written through `cfg_addr` = {0, table, output[2:0], field}. Field 0 is the ratio, taken from `cfg_wdata[7:0]`. Field 1 is the source, taken from `cfg_wdata[2:0]`.
- R4: `fsel` selects table 1 only while control bit 0 is set. Otherwise table 0 is used.
- R5: A new ratio, whether it comes from a table switch or from a write to the live table, takes effect only when the current period's low phase ends.
- R6: When the live source of an output changes, the output finishes its period, stays low for N strobes of the old source, and then restarts high on the next strobe of the new source.
- R7: While `dev_rst` is high, every output is low on the cycle after it is sampled.
- R8: With control bit 1 clear, `dev_rst` restores every table entry to source 0 and ratio 4, and writes made during reset are ignored.
- R9: With control bit 1 set, `dev_rst` keeps the tables. On the first clock after its release, every output whose live ratio is nonzero goes high together.
- R10: The control register is at `cfg_addr` bit 5 = 1, with bit 0 as the select enable and bit 1 as the reset mode. It clears only on `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| dev_rst | input | 1 | Programmable device reset, active high |
| src_tick | input | 6 | One-cycle strobes of the six sources |
| fsel | input | 1 | Table select |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_err | output | 1 | Rejected source write, one-cycle pulse |
| clk_out | output | 8 | Divided outputs |

## Verification
The assertions assume that `dev_rst`, `fsel` and the write port change only between system clock edges, synchronous to `clk`. They also assume that strobes are one cycle wide. Under these conditions, a reset release or a rejected write is visible on the next edge. The bench drives every input on the falling edge, and it produces each strobe from a counter with a fixed source period. The bench keeps each table within its source limit except in the writes that deliberately break it.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_RUN   = 2'd1,
      CH_DRAIN = 2'd2
   } chan_state_e;
endpackage

// File: rtl/cdb_profile_store.sv
module cdb_profile_store
   import cdb_pkg::*;
#(
   parameter int NUM_OUT    = 8,
   parameter int NUM_SRC    = 6,
   parameter int DIV_W      = 8,
   parameter int MAX_ACTIVE = 4,
   parameter int DEF_DIV    = 4,
   localparam int OUT_W     = $clog2(NUM_OUT),
   localparam int SEL_W     = $clog2(NUM_SRC),
   localparam int ADDR_W    = OUT_W + 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            dev_rst,
   input  logic                            fsel,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DIV_W-1:0]                wdata,
   output logic [NUM_OUT-1:0][DIV_W-1:0]   cur_div,
   output logic [NUM_OUT-1:0][SEL_W-1:0]   cur_src,
   output logic                            err
);
   localparam int SRC_PAD = 1 << SEL_W;

   logic [NUM_OUT-1:0][DIV_W-1:0] div_q [2];
   logic [NUM_OUT-1:0][SEL_W-1:0] src_q [2];
   logic                          en_q, mode_q, err_q;
   logic                          clear, wp, bad, live;
   logic [OUT_W-1:0]              wo;
   logic [SEL_W-1:0]              ns;
   logic [SRC_PAD-1:0]            cand;
   logic [SRC_PAD-1:0]            used_now [2];

   assign clear = dev_rst & ~mode_q;
   assign wp    = addr[ADDR_W-2];
   assign wo    = addr[OUT_W:1];
   assign ns    = wdata[SEL_W-1:0];
   assign live  = en_q & fsel;

   // distinct-source count of the table as it would be after the write
   always_comb begin
      cand = '0;
      for (int o = 0; o < NUM_OUT; o++) begin
         if (OUT_W'(o) == wo) cand[ns] = 1'b1;
         else                 cand[src_q[wp][o]] = 1'b1;
      end
      bad = (int'(ns) >= NUM_SRC) || ($countones(cand) > MAX_ACTIVE);
   end

   always_comb begin
      for (int p = 0; p < 2; p++) begin
         used_now[p] = '0;
         for (int o = 0; o < NUM_OUT; o++) used_now[p][src_q[p][o]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < 2; p++)
            for (int o = 0; o < NUM_OUT; o++) begin
               div_q[p][o] <= DIV_W'(DEF_DIV);
               src_q[p][o] <= '0;
            end
         en_q   <= 1'b0;
         mode_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (clear) begin
            for (int p = 0; p < 2; p++)
               for (int o = 0; o < NUM_OUT; o++) begin
                  div_q[p][o] <= DIV_W'(DEF_DIV);
                  src_q[p][o] <= '0;
               end
         end else if (we) begin
            if (addr[ADDR_W-1]) begin
               en_q   <= wdata[0];
               mode_q <= wdata[1];
            end else if (!addr[0]) begin
               div_q[wp][wo] <= wdata;
            end else if (bad) begin
               err_q <= 1'b1;
            end else begin
               src_q[wp][wo] <= ns;
            end
         end
      end
   end

   assign cur_div = live ? div_q[1] : div_q[0];
   assign cur_src = live ? src_q[1] : src_q[0];
   assign err     = err_q;

   assert_src_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(used_now[0]) <= MAX_ACTIVE) && ($countones(used_now[1]) <= MAX_ACTIVE));

   assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> ($stable(src_q[0]) && $stable(src_q[1])));
endmodule

// File: rtl/cdb_channel.sv
module cdb_channel
   import cdb_pkg::*;
#(
   parameter int NUM_SRC = 6,
   parameter int DIV_W   = 8,
   localparam int SEL_W  = $clog2(NUM_SRC),
   localparam int SRC_PAD = 1 << SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               launch,
   input  logic [NUM_SRC-1:0] tick,
   input  logic [DIV_W-1:0]   new_div,
   input  logic [SEL_W-1:0]   new_src,
   output logic               clk_out
);
   chan_state_e        st_q, st_d;
   logic [DIV_W-1:0]   pos_q, pos_d, ratio_q, ratio_d, dn, pos_inc;
   logic [SEL_W-1:0]   src_q, src_d;
   logic               out_q, out_d, last;
   logic [SRC_PAD-1:0] tick_ext;

   assign tick_ext = SRC_PAD'(tick);
   assign dn       = (new_div == DIV_W'(1)) ? DIV_W'(2) : new_div;
   assign pos_inc  = pos_q + DIV_W'(1);
   assign last     = (pos_q == ratio_q - DIV_W'(1));

   always_comb begin
      st_d = st_q; pos_d = pos_q; ratio_d = ratio_q; src_d = src_q; out_d = out_q;
      if (hold) begin
         st_d = CH_IDLE; pos_d = '0; ratio_d = '0; src_d = new_src; out_d = 1'b0;
      end else begin
         case (st_q)
            CH_IDLE: begin
               src_d = new_src;
               if (dn != '0 && (launch || tick_ext[new_src])) begin
                  st_d = CH_RUN; ratio_d = dn; pos_d = '0; out_d = 1'b1;
               end
            end
            CH_RUN: if (tick_ext[src_q]) begin
               if (last) begin
                  if (dn == '0) begin
                     st_d = CH_IDLE; ratio_d = '0; pos_d = '0; out_d = 1'b0; src_d = new_src;
                  end else if (new_src != src_q) begin
                     st_d = CH_DRAIN; pos_d = '0; out_d = 1'b0;
                  end else begin
                     pos_d = '0; ratio_d = dn; out_d = 1'b1;
                  end
               end else begin
                  pos_d = pos_inc;
                  out_d = (pos_inc < (ratio_q >> 1));
               end
            end
            CH_DRAIN: if (tick_ext[src_q]) begin
               if (last) begin
                  st_d = CH_IDLE; src_d = new_src; ratio_d = '0; pos_d = '0; out_d = 1'b0;
               end else begin
                  pos_d = pos_inc;
               end
            end
            default: st_d = CH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= CH_IDLE; pos_q <= '0; ratio_q <= '0; src_q <= '0; out_q <= 1'b0;
      end else begin
         st_q <= st_d; pos_q <= pos_d; ratio_q <= ratio_d; src_q <= src_d; out_q <= out_d;
      end
   end

   assign clk_out = out_q;

   assert_ratio_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_q) |-> (out_q || st_q == CH_IDLE));
endmodule

// File: rtl/clkout_div_bank.sv
module clkout_div_bank #(
   parameter int NUM_OUT    = 8,
   parameter int NUM_SRC    = 6,
   parameter int DIV_W      = 8,
   parameter int MAX_ACTIVE = 4,
   parameter int DEF_DIV    = 4,
   localparam int OUT_W     = $clog2(NUM_OUT),
   localparam int SEL_W     = $clog2(NUM_SRC),
   localparam int ADDR_W    = OUT_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dev_rst,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               fsel,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DIV_W-1:0]   cfg_wdata,
   output logic               cfg_err,
   output logic [NUM_OUT-1:0] clk_out
);
   if (MAX_ACTIVE > NUM_SRC || NUM_SRC < 2) begin : g_bad_src
      $error("clkout_div_bank: MAX_ACTIVE must not exceed NUM_SRC, NUM_SRC at least 2");
   end
   if (SEL_W > DIV_W || DEF_DIV >= (1 << DIV_W)) begin : g_bad_width
      $error("clkout_div_bank: DIV_W too narrow for source index or default ratio");
   end

   logic                          rst_q, launch;
   logic [NUM_OUT-1:0][DIV_W-1:0] cur_div;
   logic [NUM_OUT-1:0][SEL_W-1:0] cur_src;
   logic [NUM_OUT-1:0]            en_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= dev_rst;
   end
   assign launch = rst_q & ~dev_rst;

   cdb_profile_store #(
      .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .DIV_W(DIV_W),
      .MAX_ACTIVE(MAX_ACTIVE), .DEF_DIV(DEF_DIV)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .fsel(fsel),
      .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .cur_div(cur_div), .cur_src(cur_src), .err(cfg_err)
   );

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
      cdb_channel #(.NUM_SRC(NUM_SRC), .DIV_W(DIV_W)) i_chan (
         .clk(clk), .rst_n(rst_n), .hold(dev_rst), .launch(launch),
         .tick(src_tick), .new_div(cur_div[g]), .new_src(cur_src[g]),
         .clk_out(clk_out[g])
      );
      assign en_mask[g] = (cur_div[g] != '0);
   end

   assert_reset_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst |=> (clk_out == '0));

   assert_aligned_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_rst) |=> (clk_out == $past(en_mask)));
endmodule

// File: tb/test_clkout_div_bank.sv
`timescale 1ns/1ps
module test_clkout_div_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0, dev_rst = 1'b0, fsel = 1'b0, cfg_we = 1'b0;
   logic [5:0] src_tick = '0;
   logic [5:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       cfg_err;
   logic [7:0] clk_out;

   always #4 clk = ~clk;

   clkout_div_bank i_clkout_div_bank (
      .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .src_tick(src_tick), .fsel(fsel),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_err(cfg_err), .clk_out(clk_out)
   );

   // reference model state
   int m_div [2][8];
   int m_src [2][8];
   int c_st [8], c_pos [8], c_ratio [8], c_src [8];
   bit m_en, m_mode, m_rstq, m_err;
   bit [7:0] m_out;
   int checks = 0, errors = 0;
   bit cmp_on = 0, done = 0;
   string cur_req = "R8";

   task automatic model_defaults();
      for (int p = 0; p < 2; p++)
         for (int o = 0; o < 8; o++) begin m_div[p][o] = 4; m_src[p][o] = 0; end
   endtask

   task automatic model_step();
      int ap, dn, sn, wp, wo, ns, cnt;
      bit launch, nerr;
      bit [7:0] used;
      if (!rst_n) begin
         model_defaults();
         for (int c = 0; c < 8; c++) begin c_st[c] = 0; c_pos[c] = 0; c_ratio[c] = 0; c_src[c] = 0; end
         m_en = 0; m_mode = 0; m_rstq = 0; m_err = 0; m_out = '0;
         return;
      end
      ap = (m_en && fsel) ? 1 : 0;
      launch = m_rstq && !dev_rst;
      for (int c = 0; c < 8; c++) begin
         dn = m_div[ap][c]; if (dn == 1) dn = 2;
         sn = m_src[ap][c];
         if (dev_rst) begin
            c_st[c] = 0; c_pos[c] = 0; c_ratio[c] = 0; c_src[c] = sn; m_out[c] = 0;
         end else if (c_st[c] == 0) begin
            c_src[c] = sn;
            if (dn != 0 && (launch || src_tick[sn])) begin
               c_st[c] = 1; c_ratio[c] = dn; c_pos[c] = 0; m_out[c] = 1;
            end
         end else if (src_tick[c_src[c]]) begin
            if (c_pos[c] == c_ratio[c] - 1) begin
               if (c_st[c] == 2 || dn == 0) begin
                  c_st[c] = 0; c_ratio[c] = 0; c_pos[c] = 0; m_out[c] = 0; c_src[c] = sn;
               end else if (sn != c_src[c]) begin
                  c_st[c] = 2; c_pos[c] = 0; m_out[c] = 0;
               end else begin
                  c_pos[c] = 0; c_ratio[c] = dn; m_out[c] = 1;
               end
            end else begin
               c_pos[c]++;
               if (c_st[c] == 1) m_out[c] = (c_pos[c] < c_ratio[c] / 2);
            end
         end
      end
      nerr = 0;
      if (dev_rst && !m_mode) model_defaults();
      else if (cfg_we) begin
         if (cfg_addr[5]) begin m_en = cfg_wdata[0]; m_mode = cfg_wdata[1]; end
         else begin
            wp = cfg_addr[4]; wo = cfg_addr[3:1]; ns = cfg_wdata[2:0];
            if (!cfg_addr[0]) m_div[wp][wo] = cfg_wdata;
            else begin
               used = '0;
               for (int o = 0; o < 8; o++) used[(o == wo) ? ns : m_src[wp][o]] = 1'b1;
               cnt = $countones(used);
               if (ns >= 6 || cnt > 4) nerr = 1;
               else m_src[wp][wo] = ns;
            end
         end
      end
      m_err = nerr;
      m_rstq = dev_rst;
   endtask

   always @(posedge clk) model_step();

   task automatic check_val(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   initial forever begin
      @(negedge clk);
      if (cmp_on) begin
         check_val(cur_req, clk_out, m_out, "clk_out");
         check_val("R2", cfg_err, m_err, "cfg_err");
      end
   end

   // source strobes, each with its own fixed period
   initial begin
      int per [6] = '{1, 2, 3, 4, 5, 7};
      int cnt [6] = '{0, 0, 0, 0, 0, 0};
      forever begin
         @(negedge clk);
         for (int s = 0; s < 6; s++) begin
            cnt[s]++;
            src_tick[s] = (cnt[s] % per[s] == 0);
         end
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(bit ctl, bit p, int o, bit fld, int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {ctl, p, 3'(o), fld}; cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int srcs0 [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
      int divs0 [8] = '{1, 2, 3, 5, 0, 7, 4, 9};
      int srcs1 [8] = '{0, 1, 4, 5, 0, 1, 4, 5};
      int divs1 [8] = '{3, 6, 2, 3, 2, 7, 0, 11};
      bit [7:0] exp_mask;
      wait_n(4);
      // reset state
      check_val("R8", clk_out, 0, "clk_out in reset");
      check_val("R8", cfg_err, 0, "cfg_err in reset");
      @(negedge clk); rst_n = 1'b1;
      cmp_on = 1;
      cur_req = "R1";
      wait_n(40);
      for (int o = 0; o < 8; o++) begin
         wr(0, 0, o, 0, divs0[o]);
         wr(0, 0, o, 1, srcs0[o]);
      end
      wait_n(300);
      // R2: fifth source, then an out-of-range index, then a legal write
      wr(0, 0, 4, 1, 4);
      check_val("R2", cfg_err, 1, "fifth source rejected");
      wr(0, 0, 4, 1, 6);
      check_val("R2", cfg_err, 1, "index 6 rejected");
      wr(0, 0, 4, 1, 1);
      check_val("R2", cfg_err, 0, "legal source accepted");
      wait_n(60);
      // R3: fill table 1
      cur_req = "R3";
      for (int o = 0; o < 8; o++) begin
         wr(0, 1, o, 0, divs1[o]);
         wr(0, 1, o, 1, srcs1[o]);
      end
      // R4: select without the enable bit
      cur_req = "R4";
      fsel = 1'b1;
      wait_n(120);
      // R6: enable the select, sources move
      cur_req = "R6";
      wr(1, 0, 0, 0, 1);
      wait_n(300);
      // R5: repeated switching and writes to the live table
      cur_req = "R5";
      for (int k = 0; k < 6; k++) begin
         fsel = ~fsel;
         wait_n(37 + 23 * k);
      end
      fsel = 1'b0;
      wr(0, 0, 5, 0, 3);
      wr(0, 0, 1, 0, 5);
      wait_n(200);
      // R7/R8: clearing reset, write during it is lost
      cur_req = "R8";
      @(negedge clk); dev_rst = 1'b1;
      wr(0, 0, 0, 0, 9);
      wait_n(8);
      @(negedge clk); dev_rst = 1'b0;
      wait_n(150);
      // R10/R9: keeping reset with aligned relaunch
      cur_req = "R9";
      wr(1, 0, 0, 0, 3);
      for (int o = 0; o < 8; o++) begin
         wr(0, 0, o, 0, divs0[o]);
         wr(0, 0, o, 1, srcs0[o]);
      end
      wait_n(50);
      cur_req = "R7";
      @(negedge clk); dev_rst = 1'b1;
      wait_n(1);
      check_val("R7", clk_out, 0, "outputs low in reset");
      wait_n(5);
      @(negedge clk); dev_rst = 1'b0;
      exp_mask = '0;
      for (int o = 0; o < 8; o++) exp_mask[o] = (divs0[o] != 0);
      @(negedge clk);
      check_val("R9", clk_out, exp_mask, "aligned first high");
      cur_req = "R9";
      wait_n(250);
      // R10: control survives the device reset
      cur_req = "R10";
      fsel = 1'b1;
      wait_n(200);
      cmp_on = 0;
      finish_run();
   end
endmodule